// File: doc/BRIEF.md
# Timer Clock Source Selector

This block produces the count-enable ticks for two free-running counters that sit under a timer: one serves a capture/compare unit, the other a PWM unit. A single free-running divider of the system clock offers six tick strobes, at one system clock in every 4, 8, 16, 32, 64 or 128. Each unit has its own 3-bit select. The select picks one of those strobes, or the external clock pin, or nothing at all. The two counters are held inside the block and advance once per selected tick.

The external clock pin is asynchronous. It passes through a two-stage synchroniser and then a two-sample agreement filter. The filter's output is the qualified level of the pin, and it changes only when two successive synchronised samples agree. A rising transition of that qualified level gives a one-cycle tick. A pulse that is wider than two system clocks therefore always counts. A pulse that is narrower than one system clock never counts. The qualified level is also brought out, so the pin can serve as a general-purpose input.

Top module: `tmr_clk_sel`

## Requirements
- R1: While `rst` is high on a rising clock edge, both counters, both tick strobes and `ext_level` are 0 after that edge.
- R2: Select codes 0 to 5 pick the divide-by-4, 8, 16, 32, 64 and 128 strobes. The divider restarts at reset. After N clock edges out of reset, a counter on code k holds floor(N / 2^(k+2)).
- R3: Select code 7 turns the source off. The tick stays low and the counter stays at its value.
- R4: Each unit uses its own select, and the two counters advance independently of one another.
- R5: A counter that holds its all-ones value wraps to 0 on its next tick.
- R6: Select code 6 takes the external pin. A high pulse on the pin longer than two system clocks advances the counter by exactly one.
- R7: A high pulse shorter than one system clock does not advance the counter. A low pulse of that width inside a high level does not advance it either.
- R8: `ext_level` follows a steady pin level after exactly four rising clock edges.
- R9: A tick strobe is high for one cycle per advance. The counter value after the edge equals the value before it plus one, and it is unchanged in cycles without a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_pin | input | 1 | Raw asynchronous external clock pin |
| cc_sel | input | 3 | Source select for the capture/compare counter (0-5 divider, 6 external, 7 off) |
| pwm_sel | input | 3 | Source select for the PWM counter (same encoding) |
| cc_count | output | 16 | Capture/compare free-running counter |
| pwm_count | output | 16 | PWM free-running counter |
| cc_tick | output | 1 | Capture/compare count-enable strobe |
| pwm_tick | output | 1 | PWM count-enable strobe |
| ext_level | output | 1 | Qualified synchronised level of the external pin |

## Verification
Some rules are checked by the assertions on every cycle:
- each counter steps by one on a tick and holds without one;
- the external tick never lasts two cycles and never comes while the qualified level is low;
- every slower divider strobe coincides with all of the faster ones.

Other behaviour needs the bench's scenarios:
- the exact division ratio for each select code;
- the off code;
- the wrap at the all-ones value;
- the four-edge latency of the level;
- the rule that separates wide pulses, which count, from glitches shorter than a clock, which do not.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int NUM_TAPS   = 6;
    localparam int TAP_SHIFT  = 2;
    localparam int PRE_W      = NUM_TAPS + TAP_SHIFT - 1;
    localparam int SEL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_DIV4   = 3'd0,
        SRC_DIV8   = 3'd1,
        SRC_DIV16  = 3'd2,
        SRC_DIV32  = 3'd3,
        SRC_DIV64  = 3'd4,
        SRC_DIV128 = 3'd5,
        SRC_EXT    = 3'd6,
        SRC_OFF    = 3'd7
    } src_sel_e;

    typedef struct packed {
        logic level;
        logic rise;
    } ext_stat_t;

    function automatic logic pick_tick(input logic [SEL_W-1:0] sel,
                                       input logic [NUM_TAPS-1:0] taps,
                                       input logic ext_rise);
        logic r;
        r = 1'b0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            if (sel == SEL_W'(k)) r = taps[k];
        end
        if (src_sel_e'(sel) == SRC_EXT) r = ext_rise;
        return r;
    endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler
    import tcs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    output logic [NUM_TAPS-1:0] taps
);

    logic [PRE_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign taps[k] = &div_q[k+TAP_SHIFT-1:0];
    end

    for (genvar k = 1; k < NUM_TAPS; k++) begin : g_nest
        // R2
        tap_nesting_chk: assert property (@(posedge clk) disable iff (rst)
            taps[k] |-> taps[k-1]);
    end

endmodule

// File: rtl/tcs_ext_qual.sv
module tcs_ext_qual
    import tcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    output ext_stat_t stat
);

    logic meta_q, sync_q, hist_q;
    logic level_q, rise_q;
    logic both_hi, both_lo;

    assign both_hi = sync_q & hist_q;
    assign both_lo = ~sync_q & ~hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= 1'b0;
            sync_q  <= 1'b0;
            hist_q  <= 1'b0;
            level_q <= 1'b0;
            rise_q  <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            hist_q <= sync_q;
            if (both_hi)      level_q <= 1'b1;
            else if (both_lo) level_q <= 1'b0;
            rise_q <= both_hi & ~level_q;
        end
    end

    assign stat.level = level_q;
    assign stat.rise  = rise_q;

    // R9
    ext_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise_q |=> !rise_q);

    // R6
    ext_rise_level_chk: assert property (@(posedge clk) disable iff (rst)
        rise_q |-> level_q);

endmodule

// File: rtl/tcs_counter.sv
module tcs_counter
    import tcs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                ext_rise,
    output logic [CNT_W-1:0]    count,
    output logic                tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = pick_tick(sel, taps, ext_rise);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (src_sel_e'(sel) == SRC_OFF) |-> !tick);

    // R1
    cnt_reset_chk: assert property (@(posedge clk)
        rst |=> cnt_q == '0);

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
    import tcs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_clk_pin,
    input  logic [SEL_W-1:0] cc_sel,
    input  logic [SEL_W-1:0] pwm_sel,
    output logic [CNT_W-1:0] cc_count,
    output logic [CNT_W-1:0] pwm_count,
    output logic             cc_tick,
    output logic             pwm_tick,
    output logic             ext_level
);

    localparam int NUM_UNITS = 2;

    logic [NUM_TAPS-1:0]  taps;
    ext_stat_t            ext_stat;
    logic [SEL_W-1:0]     sel_v  [NUM_UNITS];
    logic [CNT_W-1:0]     cnt_v  [NUM_UNITS];
    logic [NUM_UNITS-1:0] tick_v;

    tcs_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .taps (taps)
    );

    tcs_ext_qual u_ext (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_clk_pin),
        .stat (ext_stat)
    );

    assign sel_v[0] = cc_sel;
    assign sel_v[1] = pwm_sel;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        tcs_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .sel      (sel_v[u]),
            .taps     (taps),
            .ext_rise (ext_stat.rise),
            .count    (cnt_v[u]),
            .tick     (tick_v[u])
        );
    end

    assign cc_count  = cnt_v[0];
    assign pwm_count = cnt_v[1];
    assign cc_tick   = tick_v[0];
    assign pwm_tick  = tick_v[1];
    assign ext_level = ext_stat.level;

    // R4
    same_src_chk: assert property (@(posedge clk) disable iff (rst)
        (cc_sel == pwm_sel) |-> (cc_tick == pwm_tick));

endmodule

// File: tb/tmr_clk_sel_test.sv
module tmr_clk_sel_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin = 1'b0;
    logic [2:0]  cc_sel = 3'd0;
    logic [2:0]  pwm_sel = 3'd0;
    logic [15:0] cc_count, pwm_count;
    logic        cc_tick, pwm_tick, ext_level;
    logic [7:0]  w_cc_count, w_pwm_count;
    logic        w_cc_tick, w_pwm_tick, w_ext_level;

    int checks = 0;
    int errors = 0;
    int cc_ticks = 0;
    int pwm_ticks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_clk_sel uut (
        .clk(clk), .rst(rst), .ext_clk_pin(pin),
        .cc_sel(cc_sel), .pwm_sel(pwm_sel),
        .cc_count(cc_count), .pwm_count(pwm_count),
        .cc_tick(cc_tick), .pwm_tick(pwm_tick), .ext_level(ext_level)
    );

    tmr_clk_sel #(.CNT_W(8)) uut_w (
        .clk(clk), .rst(rst), .ext_clk_pin(pin),
        .cc_sel(cc_sel), .pwm_sel(pwm_sel),
        .cc_count(w_cc_count), .pwm_count(w_pwm_count),
        .cc_tick(w_cc_tick), .pwm_tick(w_pwm_tick), .ext_level(w_ext_level)
    );

    typedef struct packed {
        logic [2:0]  sa;
        logic [2:0]  sb;
        logic [31:0] n;
        logic [15:0] ea;
        logic [15:0] eb;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 3'd1, 32'd40,  16'd10, 16'd5},
        '{3'd2, 3'd3, 32'd100, 16'd6,  16'd3},
        '{3'd4, 3'd5, 32'd300, 16'd4,  16'd2},
        '{3'd5, 3'd0, 32'd130, 16'd1,  16'd32},
        '{3'd7, 3'd2, 32'd64,  16'd0,  16'd4},
        '{3'd1, 3'd7, 32'd33,  16'd4,  16'd0},
        '{3'd3, 3'd4, 32'd257, 16'd8,  16'd4}
    };

    task automatic check(input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            cc_ticks  += int'(cc_tick);
            pwm_ticks += int'(pwm_tick);
        end
    endtask

    task automatic do_reset(input logic [2:0] sa, input logic [2:0] sb);
        @(negedge clk);
        rst = 1'b1;
        cc_sel = sa;
        pwm_sel = sb;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cc_ticks = 0;
        pwm_ticks = 0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "cc_count", int'(cc_count), 0);
        check("R1", "pwm_count", int'(pwm_count), 0);
        check("R1", "cc_tick", int'(cc_tick), 0);
        check("R1", "pwm_tick", int'(pwm_tick), 0);
        check("R1", "ext_level", int'(ext_level), 0);

        // R2 R3 R4 R9: vector table
        for (int v = 0; v < NV; v++) begin
            do_reset(VECS[v].sa, VECS[v].sb);
            cycles(int'(VECS[v].n));
            check("R2", "cc_count", int'(cc_count), int'(VECS[v].ea));
            check("R4", "pwm_count", int'(pwm_count), int'(VECS[v].eb));
            check("R9", "cc ticks", cc_ticks, int'(VECS[v].ea));
            check("R9", "pwm ticks", pwm_ticks, int'(VECS[v].eb));
        end

        // R1: reset mid-run clears counters
        do_reset(3'd0, 3'd0);
        cycles(20);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "cc_count after reset", int'(cc_count), 0);
        rst = 1'b0;

        // R5: wrap on the 8-bit instance
        do_reset(3'd0, 3'd7);
        cycles(1020);
        check("R5", "count before wrap", int'(w_cc_count), 255);
        cycles(4);
        check("R5", "count after wrap", int'(w_cc_count), 0);

        // R6 R8: wide pulse, external on cc, off on pwm
        do_reset(3'd6, 3'd7);
        pin = 1'b1;
        cycles(3);
        check("R8", "level after 3 edges", int'(ext_level), 0);
        cycles(1);
        check("R8", "level after 4 edges", int'(ext_level), 1);
        pin = 1'b0;
        cycles(3);
        check("R8", "level low after 3 edges", int'(ext_level), 1);
        cycles(1);
        check("R8", "level low after 4 edges", int'(ext_level), 0);
        cycles(6);
        check("R6", "count after wide pulse", int'(cc_count), 1);
        check("R9", "ticks after wide pulse", cc_ticks, 1);
        check("R4", "pwm off", int'(pwm_count), 0);

        // R6: 3-cycle pulse counts once
        pin = 1'b1;
        cycles(3);
        pin = 1'b0;
        cycles(10);
        check("R6", "count after 3-cycle pulse", int'(cc_count), 2);

        // R7: narrow high glitch straddling an edge
        #(CLK_PERIOD/2 - 1);
        pin = 1'b1;
        #2;
        pin = 1'b0;
        cycles(10);
        check("R7", "count after high glitch", int'(cc_count), 2);
        check("R7", "level after high glitch", int'(ext_level), 0);

        // R7: narrow low glitch inside a high level
        pin = 1'b1;
        cycles(8);
        check("R6", "count after rise", int'(cc_count), 3);
        #(CLK_PERIOD/2 - 1);
        pin = 1'b0;
        #2;
        pin = 1'b1;
        cycles(10);
        check("R7", "count after low glitch", int'(cc_count), 3);
        check("R7", "level after low glitch", int'(ext_level), 1);
        pin = 1'b0;
        cycles(8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule